// File: doc/BRIEF.md
# Convolutional Bit Interleaver / De-interleaver Pair

This block spreads burst errors on a serial radio link across many codewords. An interleaver core sends each valid input bit through a rotating selector into one of 16 delay branches. Branch j holds j one-bit cells and shifts only when it is selected, so a bit on branch j leaves 16·j valid bits later. A de-interleaver core uses the same selector order with 15−j cells on branch j. Every bit therefore crosses 15 cells in total, and the original order comes back after 240 valid bits.

Each core has a one-bit data input and a one-bit data output, each with a valid strobe. Each core also has two register stages: one captures the input and one registers the branch output. The pair module chains the two cores back to back. It brings out both the interleaved stream and the restored stream, so the link can be looped back and checked. The branch count and the span are parameters. The per-branch cell step is derived as span divided by branch count.

Top module: `conv_ilv_pair`

## Requirements
- R1: With 16 branches and a step of one cell, the k-th valid interleaved bit (k counted from 0 after reset) equals input bit k − 16·(k mod 16), or 0 when that index is negative.
- R2: The k-th valid restored bit equals input bit k − 240, or 0 for k < 240. The de-interleaver branch j holds 15 − j cells.
- R3: After reset both selectors point at branch 0. Each selector advances by one branch per valid bit and wraps from branch 15 to branch 0. A reset in mid-stream restarts the sequence at branch 0.
- R4: Cycles with the input valid low change no selector and no branch cell. The valid-indexed output streams are identical to those of a gap-free run with the same valid bits.
- R5: The interleaved valid strobe equals the input valid of 2 cycles earlier, and the restored valid strobe equals it 4 cycles earlier. With a continuous stream, input bit k reappears at the restored output exactly 244 cycles after it is applied.
- R6: A synchronous active-high reset clears all cells and outputs to 0. While the restored output is still filling, it is valid but carries 0.
- R7: Adjacent valid input bits never come out adjacent in the interleaved stream. A burst of 8 consecutive ones inside a zero stream gives exactly 8 isolated ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Data bit into the interleaver |
| in_vld | input | 1 | Marks in_bit as valid |
| ilv_bit | output | 1 | Interleaved data bit |
| ilv_vld | output | 1 | Marks ilv_bit as valid |
| out_bit | output | 1 | Restored data bit |
| out_vld | output | 1 | Marks out_bit as valid |

## Verification
The hardest case to reach from the ports is a stream with idle gaps that sits at the selector wrap while older bits are still in the longest branches. If the cells move at all on an idle cycle, the error only shows up about 240 valid bits later. The stimulus therefore runs long random streams with roughly one idle cycle in three, after a reset in mid-stream. The scoreboard, indexed by valid bits, checks every interleaved and restored bit. A separate run places a short burst of ones in a zero stream and confirms that it is scattered at the interleaved output. A continuous run measures the exact 244-cycle arrival of the first restored bit.

// File: rtl/conv_ilv_pkg.sv
package conv_ilv_pkg;

    // Cell count of branch j: growing for the interleaver, shrinking for the de-interleaver
    function automatic int branch_len(input int j, input int n_br, input int step, input bit rev);
        return rev ? (n_br - 1 - j) * step : j * step;
    endfunction

endpackage

// File: rtl/conv_ilv_branch.sv
module conv_ilv_branch #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic din,
    output logic dout
);

    generate
        if (LEN == 0) begin : g_pass
            logic unused_ok;
            assign unused_ok = ^{clk, rst, shift_en};
            assign dout = din;
        end else begin : g_cells
            logic [LEN-1:0] cells_d, cells_q;

            always_comb begin
                cells_d = cells_q;
                if (shift_en) begin
                    cells_d = LEN'({cells_q, din});
                end
            end

            always_ff @(posedge clk) begin
                if (rst) cells_q <= '0;
                else     cells_q <= cells_d;
            end

            // oldest cell leaves when the branch is selected
            assign dout = cells_q[LEN-1];

            AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (rst)
                !shift_en |=> $stable(cells_q)); // R4
        end
    endgenerate

endmodule

// File: rtl/conv_ilv_core.sv
module conv_ilv_core #(
    parameter int N_BR    = 16,
    parameter int STEP    = 1,
    parameter bit REVERSE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    input  logic in_vld,
    output logic out_bit,
    output logic out_vld
);

    localparam int SEL_W = (N_BR > 1) ? $clog2(N_BR) : 1;
    localparam logic [SEL_W-1:0] LAST = SEL_W'(N_BR - 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;     // selector for the next valid bit
        logic             a_bit;   // capture stage
        logic             a_vld;
        logic [SEL_W-1:0] a_sel;
        logic             o_bit;   // output stage
        logic             o_vld;
    } core_state_t;

    core_state_t s_d, s_q;
    logic [N_BR-1:0] taps;
    logic [N_BR-1:0] shift_en;

    always_comb begin
        s_d       = s_q;
        s_d.a_vld = in_vld;
        s_d.o_vld = s_q.a_vld;
        if (in_vld) begin
            s_d.a_bit = in_bit;
            s_d.a_sel = s_q.sel;
            s_d.sel   = (s_q.sel == LAST) ? '0 : s_q.sel + 1'b1;
        end
        if (s_q.a_vld) begin
            s_d.o_bit = taps[s_q.a_sel];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        for (int j = 0; j < N_BR; j++) begin
            shift_en[j] = s_q.a_vld && (s_q.a_sel == SEL_W'(j));
        end
    end

    generate
        for (genvar j = 0; j < N_BR; j++) begin : g_br
            conv_ilv_branch #(
                .LEN(conv_ilv_pkg::branch_len(j, N_BR, STEP, REVERSE))
            ) u_br (
                .clk      (clk),
                .rst      (rst),
                .shift_en (shift_en[j]),
                .din      (s_q.a_bit),
                .dout     (taps[j])
            );
        end
    endgenerate

    assign out_bit = s_q.o_bit;
    assign out_vld = s_q.o_vld;

    AST_SEL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (in_vld && s_q.sel == LAST) |=> (s_q.sel == '0)); // R3
    AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_vld && s_q.sel != LAST) |=> (s_q.sel == $past(s_q.sel) + 1'b1)); // R3
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(s_q.sel)); // R4
    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(shift_en)); // R1
    AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ##1 out_vld); // R5
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ##1 !out_vld); // R5

endmodule

// File: rtl/conv_ilv_pair.sv
module conv_ilv_pair #(
    parameter int N_BR = 16,
    parameter int SPAN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    input  logic in_vld,
    output logic ilv_bit,
    output logic ilv_vld,
    output logic out_bit,
    output logic out_vld
);

    localparam int STEP = SPAN / N_BR;

    conv_ilv_core #(
        .N_BR    (N_BR),
        .STEP    (STEP),
        .REVERSE (1'b0)
    ) u_ilv (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (in_bit),
        .in_vld  (in_vld),
        .out_bit (ilv_bit),
        .out_vld (ilv_vld)
    );

    conv_ilv_core #(
        .N_BR    (N_BR),
        .STEP    (STEP),
        .REVERSE (1'b1)
    ) u_dil (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (ilv_bit),
        .in_vld  (ilv_vld),
        .out_bit (out_bit),
        .out_vld (out_vld)
    );

    AST_PAIR_VLD: assert property (@(posedge clk) disable iff (rst)
        ilv_vld |=> ##1 out_vld); // R5

endmodule

// File: tb/conv_ilv_pair_tb_top.sv
module conv_ilv_pair_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic in_bit = 1'b0;
    logic in_vld = 1'b0;
    logic ilv_bit, ilv_vld, out_bit, out_vld;

    conv_ilv_pair dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (in_bit),
        .in_vld  (in_vld),
        .ilv_bit (ilv_bit),
        .ilv_vld (ilv_vld),
        .out_bit (out_bit),
        .out_vld (out_vld)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int out_cnt = 0;
    int start_cyc = 0;
    bit lat_en = 1'b0;
    bit done = 1'b0;

    bit in_list[$];
    bit exp_ilv[$];
    bit exp_out[$];
    bit vhist[$];
    bit ilv_log[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: applies one cycle of input and pushes the expected items
    task automatic send(input bit b, input bit v);
        @(posedge clk);
        #1;
        in_bit = b;
        in_vld = v;
        if (v) begin
            int k, j, idx;
            if (in_list.size() == 0) start_cyc = cyc;
            in_list.push_back(b);
            k   = in_list.size() - 1;
            j   = k % 16;
            idx = k - 16 * j;
            exp_ilv.push_back(idx >= 0 ? in_list[idx] : 1'b0);
            exp_out.push_back(k >= 240 ? in_list[k - 240] : 1'b0);
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        in_vld = 1'b0;
        in_bit = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(ilv_vld == 1'b0, "R6", "ilv_vld in reset", ilv_vld, 0);
        check(out_vld == 1'b0, "R6", "out_vld in reset", out_vld, 0);
        check(ilv_bit == 1'b0, "R6", "ilv_bit in reset", ilv_bit, 0);
        check(out_bit == 1'b0, "R6", "out_bit in reset", out_bit, 0);
        in_list.delete();
        exp_ilv.delete();
        exp_out.delete();
        ilv_log.delete();
        out_cnt = 0;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // monitor: pops the scoreboard as outputs appear
    initial begin
        forever begin
            @(negedge clk);
            vhist.push_back(in_vld);
            if (vhist.size() > 8) void'(vhist.pop_front());
            if (!rst) begin
                if (vhist.size() >= 5) begin
                    check(ilv_vld == vhist[vhist.size() - 3], "R5", "ilv_vld vs input 2 cycles back",
                          ilv_vld, vhist[vhist.size() - 3]);
                    check(out_vld == vhist[vhist.size() - 5], "R5", "out_vld vs input 4 cycles back",
                          out_vld, vhist[vhist.size() - 5]);
                end
                if (ilv_vld) begin
                    ilv_log.push_back(ilv_bit);
                    if (exp_ilv.size() == 0) check(1'b0, "R1", "unexpected interleaved bit", 1, 0);
                    else begin
                        bit e;
                        e = exp_ilv.pop_front();
                        check(ilv_bit == e, "R1 R3", "interleaved bit", ilv_bit, e);
                    end
                end
                if (out_vld) begin
                    if (exp_out.size() == 0) check(1'b0, "R2", "unexpected restored bit", 1, 0);
                    else begin
                        bit e;
                        e = exp_out.pop_front();
                        check(out_bit == e, "R2", "restored bit", out_bit, e);
                    end
                    if (out_cnt < 240) check(out_bit == 1'b0, "R6", "fill value", out_bit, 0);
                    if (lat_en && out_cnt == 240)
                        check(cyc - start_cyc == 244, "R5", "end-to-end cycles", cyc - start_cyc, 244);
                    out_cnt++;
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();

        // continuous random stream: mapping, restoration, 244-cycle arrival
        lat_en = 1'b1;
        repeat (700) send(1'($urandom % 2), 1'b1);
        repeat (6) send(1'b0, 1'b0);
        lat_en = 1'b0;

        // mid-stream reset, then random stream with idle gaps (R4, R3 restart)
        repeat (37) send(1'($urandom % 2), 1'b1);
        do_reset();
        repeat (1500) send(1'($urandom % 2), 1'(($urandom % 3) != 0));
        repeat (12) send(1'b0, 1'b0);
        check(exp_ilv.size() == 0, "R4", "pending interleaved items", exp_ilv.size(), 0);
        check(exp_out.size() == 0, "R4", "pending restored items", exp_out.size(), 0);

        // burst of ones in a zero stream (R7)
        do_reset();
        repeat (200) send(1'b0, 1'b1);
        repeat (8) send(1'b1, 1'b1);
        repeat (450) send(1'b0, 1'b1);
        repeat (8) send(1'b0, 1'b0);
        begin
            int ones;
            int adj;
            ones = 0;
            adj = 0;
            for (int i = 0; i < ilv_log.size(); i++) begin
                if (ilv_log[i]) ones++;
                if (i > 0 && ilv_log[i] && ilv_log[i-1]) adj++;
            end
            check(ones == 8, "R7", "ones in interleaved stream", ones, 8);
            check(adj == 0, "R7", "adjacent ones in interleaved stream", adj, 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule